// File: doc/BRIEF.md
# Link Handshake Responder

This block sits behind a packet deframer on a host-controller serial link. It takes one complete packet at a time as a byte stream. The first byte is the packet type. The block answers the link-establishment messages by itself: negotiation packets, keep-alive packets, and the vendor firmware-download command. Each answer goes out byte by byte into a transmit queue, under a valid/ready handshake. Standard command, ACL and SCO packets are not answered. For each of them the block raises a one-cycle forward strobe so that a neighbouring path can pass the packet on. Every other packet is malformed: it raises a one-cycle error strobe and gets no answer.

A firmware-download command may carry a 6-byte device address at fixed payload positions. The address bytes are stored there in a scrambled order. The block reorders them and latches the result on its address output.

Only a decision and a short reply are stored. Input bytes are reduced to flags and shadow registers as they arrive. The decision is made in the cycle after the last byte. While a reply is being drained, input is held off.

Top module: `link_handshake_responder`

## Requirements
- R1: After reset, `tx_valid`, `err_pulse`, `fwd_pulse` and `addr_load` are low, `dev_addr` is zero and `in_ready` is high.
- R2: A packet of exactly 12 bytes equal to 06 0A 00 A0 01 00 00 4C 00 96 00 00 is answered with the 12 bytes 06 0A 20, then input bytes 3 to 9 (A0 01 00 00 4C 00 96), then FF FF.
- R3: A type-06 packet that differs from that pattern in any byte, or that has any other length, pulses `err_pulse` and produces no reply.
- R4: A 4-byte type-07 packet with byte 2 = 0x55 and byte 3 = 0x00 (byte 1 is free) is answered with 07 02 CC 00.
- R5: A type-07 packet with any other length or with other values in byte 2 or 3 pulses `err_pulse` and produces no reply.
- R6: A type-04 (event) packet, and a packet whose type is not 01, 02, 03, 04, 06 or 07, pulses `err_pulse` and produces no reply.
- R7: A type-02 or type-03 packet, and a type-01 packet of at least 4 bytes whose opcode group is not the vendor group, pulses `fwd_pulse` once, with no error and no reply. The opcode is bytes 1 (low) and 2 (high), the group is opcode bits 15:10, the vendor group is 0x3F, and the command field is bits 9:0.
- R8: A type-01 vendor packet with command field 0 (firmware download) is always answered with the 14 bytes 04 FF 0B followed by 11 zero bytes.
- R9: The address is captured from a firmware download only when the payload, starting at byte 4, is at least 26 bytes long (total length at least 30) and payload bytes 12 and 13 are 0x01 and 0x00. Then `addr_load` pulses, and `dev_addr[8k+7:8k]` for k = 0..5 takes payload byte 25, 24, 22, 18, 21, 20 respectively.
- R10: A firmware download that is shorter than 30 bytes, or that has other values in payload bytes 12 and 13, leaves `dev_addr` unchanged and does not pulse `addr_load`. It is still answered.
- R11: A vendor command with a nonzero command field, and a type-01 packet shorter than 4 bytes, pulses `err_pulse` and produces no reply.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold. `in_ready` is low from the cycle after a packet's last byte until the last reply byte is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input packet byte, type byte first |
| in_last | input | 1 | Marks the final byte of a packet |
| in_ready | output | 1 | Block accepts an input byte |
| tx_valid | output | 1 | Reply byte valid |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Transmit queue takes the reply byte |
| fwd_pulse | output | 1 | One-cycle strobe: standard packet to forward |
| err_pulse | output | 1 | One-cycle strobe: malformed packet |
| addr_load | output | 1 | One-cycle strobe: device address updated |
| dev_addr | output | 48 | Captured device address, byte 0 in bits 7:0 |

## Verification
A wrong match flag or a wrong byte count shows at the ports two cycles after the last input byte. One of three things then happens where something else was due: an error strobe, a forward strobe, or the first reply byte. A fault in the reply sequencer shows as a wrong byte or a wrong reply length once the queue has taken the reply. A fault in the address shadow shows on `dev_addr` when `addr_load` pulses. Random packets of every kind, including corrupted ones, are compared with a model that works only from the byte rules.

// File: rtl/link_handshake_responder.sv
module link_handshake_responder #(
  parameter int CNT_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        in_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_ready,
  output logic        fwd_pulse,
  output logic        err_pulse,
  output logic        addr_load,
  output logic [47:0] dev_addr
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [1:0] {RK_NONE, RK_NEG, RK_KA, RK_VEND} rk_t;

  function automatic logic [7:0] neg_pat(input logic [3:0] i);
    case (i)
      4'd0: neg_pat = 8'h06;
      4'd1: neg_pat = 8'h0A;
      4'd3: neg_pat = 8'hA0;
      4'd4: neg_pat = 8'h01;
      4'd7: neg_pat = 8'h4C;
      4'd9: neg_pat = 8'h96;
      default: neg_pat = 8'h00;
    endcase
  endfunction

  logic [CNT_W-1:0] cnt;
  logic [7:0]  typ;
  logic [15:0] opc;
  logic        neg_ok, ka_ok, tag_ok, done;
  logic [47:0] addr_sh;
  rk_t         kind, dec_kind;
  logic [3:0]  idx, last_idx;
  logic        dec_err, dec_fwd, dec_load;

  wire acc = in_valid && in_ready;
  wire vend = (opc[15:10] == 6'h3F);
  wire fw = vend && (opc[9:0] == 10'd0);

  assign in_ready = !done && (kind == RK_NONE);
  assign tx_valid = (kind != RK_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; typ <= '0; opc <= '0; addr_sh <= '0;
      neg_ok <= 1'b0; ka_ok <= 1'b0; tag_ok <= 1'b0; done <= 1'b0;
    end else begin
      done <= acc && in_last;
      if (done) cnt <= '0;
      if (acc) begin
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        if (cnt == '0) begin
          typ <= in_data;
          neg_ok <= (in_data == 8'h06);
          ka_ok <= 1'b1;
          tag_ok <= 1'b1;
        end else begin
          if (cnt < CNT_W'(12) && in_data != neg_pat(cnt[3:0])) neg_ok <= 1'b0;
          if (cnt == CNT_W'(2) && in_data != 8'h55) ka_ok <= 1'b0;
          if (cnt == CNT_W'(3) && in_data != 8'h00) ka_ok <= 1'b0;
          if (cnt == CNT_W'(16) && in_data != 8'h01) tag_ok <= 1'b0;
          if (cnt == CNT_W'(17) && in_data != 8'h00) tag_ok <= 1'b0;
          if (cnt == CNT_W'(1)) opc[7:0] <= in_data;
          if (cnt == CNT_W'(2)) opc[15:8] <= in_data;
          if (cnt == CNT_W'(29)) addr_sh[7:0]   <= in_data;
          if (cnt == CNT_W'(28)) addr_sh[15:8]  <= in_data;
          if (cnt == CNT_W'(26)) addr_sh[23:16] <= in_data;
          if (cnt == CNT_W'(22)) addr_sh[31:24] <= in_data;
          if (cnt == CNT_W'(25)) addr_sh[39:32] <= in_data;
          if (cnt == CNT_W'(24)) addr_sh[47:40] <= in_data;
        end
      end
    end
  end

  always_comb begin
    dec_kind = RK_NONE; dec_err = 1'b0; dec_fwd = 1'b0; dec_load = 1'b0;
    case (typ)
      8'h06: if (neg_ok && cnt == CNT_W'(12)) dec_kind = RK_NEG; else dec_err = 1'b1;
      8'h07: if (ka_ok && cnt == CNT_W'(4)) dec_kind = RK_KA; else dec_err = 1'b1;
      8'h01: begin
        if (cnt < CNT_W'(4)) dec_err = 1'b1;
        else if (fw) begin
          dec_kind = RK_VEND;
          dec_load = tag_ok && (cnt >= CNT_W'(30));
        end else if (vend) dec_err = 1'b1;
        else dec_fwd = 1'b1;
      end
      8'h02, 8'h03: dec_fwd = 1'b1;
      default: dec_err = 1'b1;
    endcase
  end

  always_comb begin
    case (kind)
      RK_NEG:  last_idx = 4'd11;
      RK_KA:   last_idx = 4'd3;
      default: last_idx = 4'd13;
    endcase
  end

  always_comb begin
    tx_data = 8'h00;
    case (kind)
      RK_NEG: begin
        if (idx == 4'd2) tx_data = 8'h20;
        else if (idx >= 4'd10) tx_data = 8'hFF;
        else tx_data = neg_pat(idx);
      end
      RK_KA: case (idx)
        4'd0: tx_data = 8'h07;
        4'd1: tx_data = 8'h02;
        4'd2: tx_data = 8'hCC;
        default: tx_data = 8'h00;
      endcase
      RK_VEND: case (idx)
        4'd0: tx_data = 8'h04;
        4'd1: tx_data = 8'hFF;
        4'd2: tx_data = 8'h0B;
        default: tx_data = 8'h00;
      endcase
      default: tx_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind <= RK_NONE; idx <= '0;
      err_pulse <= 1'b0; fwd_pulse <= 1'b0; addr_load <= 1'b0; dev_addr <= '0;
    end else begin
      err_pulse <= done && dec_err;
      fwd_pulse <= done && dec_fwd;
      addr_load <= done && dec_load;
      if (done && dec_load) dev_addr <= addr_sh;
      if (done) begin
        kind <= dec_kind;
        idx <= '0;
      end else if (tx_valid && tx_ready) begin
        if (idx == last_idx) kind <= RK_NONE;
        else idx <= idx + 1'b1;
      end
    end
  end

  p_tx_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
  p_no_input_during_reply_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !in_ready);
  p_err_fwd_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_pulse && fwd_pulse));
  p_err_no_reply_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !tx_valid);
  p_load_with_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |-> tx_valid && tx_data == 8'h04);
  p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_load |=> $stable(dev_addr) || addr_load);
endmodule

// File: tb/link_handshake_responder_tb.sv
module link_handshake_responder_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, tx_ready = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, tx_valid, fwd_pulse, err_pulse, addr_load;
  logic [7:0] tx_data;
  logic [47:0] dev_addr;

  link_handshake_responder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .fwd_pulse(fwd_pulse),
    .err_pulse(err_pulse), .addr_load(addr_load), .dev_addr(dev_addr));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] pkt [0:47];
  int pn;
  logic [7:0] rxb [0:31];
  int rn = 0, n_err = 0, n_fwd = 0, n_load = 0, hold_bad = 0, rdy_bad = 0;
  logic prev_hold = 1'b0;
  logic [7:0] prev_data = 8'h00;
  logic [7:0] exb [0:15];
  int exn, ex_err, ex_fwd, ex_load;
  logic [47:0] ex_addr = '0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic r;
    r = ($urandom % 4) != 0;
    if (rst_n) begin
      if (err_pulse) n_err++;
      if (fwd_pulse) n_fwd++;
      if (addr_load) n_load++;
      if (prev_hold && (!tx_valid || tx_data != prev_data)) hold_bad++;
      if (tx_valid && in_ready) rdy_bad++;
      if (tx_valid && r && rn < 32) begin rxb[rn] = tx_data; rn++; end
      prev_hold = tx_valid && !r;
      prev_data = tx_data;
    end
    tx_ready = r;
  end

  function automatic logic [7:0] negp(input int i);
    case (i)
      0: return 8'h06; 1: return 8'h0A; 3: return 8'hA0; 4: return 8'h01;
      7: return 8'h4C; 9: return 8'h96; default: return 8'h00;
    endcase
  endfunction

  task automatic model();
    logic [15:0] op;
    bit ok;
    exn = 0; ex_err = 0; ex_fwd = 0; ex_load = 0;
    op = {pkt[2], pkt[1]};
    case (pkt[0])
      8'h06: begin
        ok = (pn == 12);
        for (int i = 0; i < 12 && i < pn; i++) if (pkt[i] != negp(i)) ok = 0;
        if (ok) begin
          exb[0] = 8'h06; exb[1] = 8'h0A; exb[2] = 8'h20;
          for (int i = 3; i < 10; i++) exb[i] = pkt[i];
          exb[10] = 8'hFF; exb[11] = 8'hFF; exn = 12;
        end else ex_err = 1;
      end
      8'h07: if (pn == 4 && pkt[2] == 8'h55 && pkt[3] == 8'h00) begin
          exb[0] = 8'h07; exb[1] = 8'h02; exb[2] = 8'hCC; exb[3] = 8'h00; exn = 4;
        end else ex_err = 1;
      8'h01: begin
        if (pn < 4) ex_err = 1;
        else if (op[15:10] == 6'h3F && op[9:0] == 10'd0) begin
          exb[0] = 8'h04; exb[1] = 8'hFF; exb[2] = 8'h0B;
          for (int i = 3; i < 14; i++) exb[i] = 8'h00;
          exn = 14;
          if (pn >= 30 && pkt[16] == 8'h01 && pkt[17] == 8'h00) begin
            ex_load = 1;
            ex_addr = {pkt[24], pkt[25], pkt[22], pkt[26], pkt[28], pkt[29]};
          end
        end else if (op[15:10] == 6'h3F) ex_err = 1;
        else ex_fwd = 1;
      end
      8'h02, 8'h03: ex_fwd = 1;
      default: ex_err = 1;
    endcase
  endtask

  task automatic send_and_check(input string tag, input string rtag);
    int i;
    bit same;
    rn = 0; n_err = 0; n_fwd = 0; n_load = 0;
    model();
    i = 0;
    while (i < pn) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = pkt[i]; in_last = (i == pn - 1);
      if (in_ready) i++;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    repeat (4) @(negedge clk);
    while (tx_valid) @(negedge clk);
    repeat (2) @(negedge clk);
    check(n_err == ex_err, tag, n_err, ex_err);
    check(n_fwd == ex_fwd, tag, n_fwd, ex_fwd);
    check(rn == exn, rtag, rn, exn);
    same = (rn == exn);
    for (int k = 0; k < exn && k < rn; k++) if (rxb[k] != exb[k]) same = 0;
    check(same, rtag, rn > 0 ? rxb[0] : 0, exn > 0 ? exb[0] : 0);
    check(n_load == ex_load, tag, n_load, ex_load);
    check(dev_addr == ex_addr, tag, dev_addr, ex_addr);
  endtask

  task automatic fill_rand(input int n);
    pn = n;
    for (int i = 0; i < n; i++) pkt[i] = 8'($urandom);
  endtask

  task automatic build(input int sc);
    int p;
    case (sc)
      0, 1, 2: begin
        pn = (sc == 2) ? (($urandom % 2) ? 13 : 11) : 12;
        for (int i = 0; i < pn; i++) pkt[i] = negp(i);
        if (sc == 1) begin p = 1 + $urandom % 11; pkt[p] = pkt[p] ^ (8'd1 + 8'($urandom % 255)); end
      end
      3, 4: begin
        fill_rand(4); pkt[0] = 8'h07; pkt[2] = 8'h55; pkt[3] = 8'h00;
        if (sc == 4) begin
          p = $urandom % 3;
          if (p == 0) pkt[2] = 8'h54; else if (p == 1) pkt[3] = 8'h01; else pn = 5;
        end
      end
      5, 6, 7: begin
        fill_rand(sc == 6 ? 4 + $urandom % 26 : 30 + $urandom % 11);
        pkt[0] = 8'h01; pkt[1] = 8'h00; pkt[2] = 8'hFC;
        if (pn > 17) begin pkt[16] = 8'h01; pkt[17] = 8'h00; end
        if (sc == 7) begin if ($urandom % 2) pkt[16] = 8'h02; else pkt[17] = 8'h80; end
      end
      8: begin fill_rand(4 + $urandom % 10); pkt[0] = 8'h01; pkt[2] = 8'hFC | 8'($urandom % 4);
         if (pkt[2] == 8'hFC && pkt[1] == 8'h00) pkt[1] = 8'h05; end
      9: begin fill_rand(4 + $urandom % 10); pkt[0] = 8'h01; pkt[2] = 8'($urandom % 8'hFC); end
      10: begin fill_rand(2 + $urandom % 15); pkt[0] = 8'h02; end
      11: begin fill_rand(2 + $urandom % 15); pkt[0] = 8'h03; end
      12: begin fill_rand(2 + $urandom % 15); pkt[0] = 8'h04; end
      13: begin fill_rand(1 + $urandom % 15); pkt[0] = 8'h08 + 8'($urandom % 200); end
      default: begin fill_rand(1 + $urandom % 3); pkt[0] = 8'h01; end
    endcase
  endtask

  function automatic string etag(input int sc);
    case (sc)
      0: return "R2"; 1, 2: return "R3"; 3: return "R4"; 4: return "R5";
      5: return "R9"; 6, 7: return "R10"; 8, 14: return "R11";
      12, 13: return "R6"; default: return "R7";
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!tx_valid && !err_pulse && !fwd_pulse && !addr_load, "R1", tx_valid, 0);
    check(dev_addr == 48'd0 && in_ready, "R1", dev_addr, 0);
    for (int i = 0; i < 30; i++) pkt[i] = 8'(i);
    pkt[0] = 8'h01; pkt[1] = 8'h00; pkt[2] = 8'hFC; pkt[16] = 8'h01; pkt[17] = 8'h00; pn = 30;
    send_and_check("R9", "R8");
    check(dev_addr == 48'h18_19_16_1A_1C_1D, "R9", dev_addr, 48'h18_19_16_1A_1C_1D);
    pn = 29; send_and_check("R10", "R8");
    build(0); send_and_check("R2", "R2");
    build(3); send_and_check("R4", "R4");
    build(12); send_and_check("R6", "R6");
    for (int n = 0; n < 120; n++) begin
      int sc;
      sc = $urandom % 15;
      build(sc);
      send_and_check(etag(sc), (sc >= 5 && sc <= 7) ? "R8" : etag(sc));
    end
    check(hold_bad == 0, "R12", hold_bad, 0);
    check(rdy_bad == 0, "R12", rdy_bad, 0);
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule